// File: doc/BRIEF.md
# Watchdog Timer with Interrupt or Reset Response

This block is a watchdog timer that runs from the system clock. A prescaler divides the clock by a power of two, and each prescaled tick advances an 8-bit count. Software must service the watchdog before the count runs out. Servicing takes two writes to a key register: an arming key and then a firing key. When the count expires, the block raises a watchdog event. A mode bit decides what the event does. In reset mode it sends a one-cycle reset request. In interrupt mode it drives an active-low interrupt line low for a fixed number of cycles.

The control register holds the divide select, a halt bit and the mode bit, along with a 3-bit guard field. A control write whose guard field is wrong updates nothing. Instead it raises an event on the next cycle, so software can use a deliberately bad write to force an immediate reset. While an interrupt pulse is in progress, writes cannot change the mode.

Top module: `wdt_core`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1 and `rst_req` is 0. The block starts in reset mode, divides by 1 and is not halted.
- R2: The divide select `s` sets the tick period to 2^s cycles for s from 0 to 6. The value 7 behaves like 6. After a service, the expiry event appears 255 tick periods after the service write's clock edge.
- R3: The key register is address 1. Writing 0x55 arms the service logic. A later write of 0xAA while armed clears both the counter and the prescaler. Other values written in between do not disarm it. A write of 0xAA while not armed has no effect.
- R4: The control register is address 0 and is laid out as follows:
  - bits [2:0]: divide select
  - bit 3: halt
  - bit 4: mode (1 = reset request, 0 = interrupt)
  - bits [7:5]: guard field, which must be 3'b101 for the write to take effect
- R5: A control write with any other guard value updates no field. It raises a watchdog event whose output is visible in the cycle after the write edge.
- R6: In reset mode, each event drives `rst_req` high for exactly one cycle.
- R7: In interrupt mode, each event drives `irq_n` low for 512 cycles. An event that arrives during the pulse restarts the full 512-cycle window.
- R8: The mode bit of a valid control write is ignored while the interrupt pulse is active, and also in a cycle where an expiry fires.
- R9: While halt is set, the count and the prescaler hold their values, and clearing halt resumes from where they stopped. A bad-guard write still raises an immediate event while halted.
- R10: After any event, the counter and the prescaler restart from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 = control, 1 = key) |
| bus_wdata | input | 8 | Write data |
| irq_n | output | 1 | Active-low interrupt pulse |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a maximum divide shift of 6, and a 512-cycle pulse. With these values, even the slowest divide setting expires within about sixteen thousand cycles. This lets the bench sweep all eight divide selects, including the clamped value 7, and compare each expiry cycle with 255 times 2^s computed in the bench. The same configuration keeps the retriggered pulse, the mode hold-off during a pulse, and the frozen-count arithmetic under halt all cheap to reach.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KEY  = 2'd1
  } reg_sel_e;

  typedef struct packed {
    logic [2:0]       guard;
    logic             mode_rst;
    logic             halt;
    logic [SEL_W-1:0] div_sel;
  } ctrl_t;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter logic [2:0] GUARD_OK = 3'b101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             pulse_active,
  input  logic             expire,
  output logic [SEL_W-1:0] div_sel,
  output logic             halt,
  output logic             mode_rst,
  output logic             guard_bad
);
  ctrl_t w;
  logic  ctrl_wr;
  logic  mode_lock;

  assign w         = ctrl_t'(wdata);
  assign ctrl_wr   = wr && (addr == REG_CTRL);
  assign guard_bad = ctrl_wr && (w.guard != GUARD_OK);
  assign mode_lock = pulse_active || expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel  <= '0;
      halt     <= 1'b0;
      mode_rst <= 1'b1;
    end else if (ctrl_wr && !guard_bad) begin
      div_sel <= w.div_sel;
      halt    <= w.halt;
      if (!mode_lock) mode_rst <= w.mode_rst;
    end
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_active |=> $stable(mode_rst));

  // R5
  bad_guard_keeps_fields_chk: assert property (@(posedge clk) disable iff (rst)
    guard_bad |=> ($stable(div_sel) && $stable(halt) && $stable(mode_rst)));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter logic [7:0] KEY_ARM  = 8'h55,
  parameter logic [7:0] KEY_FIRE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic       svc
);
  logic armed_q;
  logic key_wr;

  assign key_wr = wr && (addr == REG_KEY);
  assign svc    = key_wr && (wdata == KEY_FIRE) && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (key_wr) begin
      if (wdata == KEY_ARM) armed_q <= 1'b1;
      else if (svc)         armed_q <= 1'b0;
    end
  end

  // R3
  svc_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    svc |=> !armed_q);

  // R3
  arm_key_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && wdata == KEY_ARM) |=> armed_q);
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             clr,
  output logic             expire
);
  localparam int unsigned PRE_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}} - CNT_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] shift;
  logic [PRE_W:0]   limit;
  logic             tick;

  assign shift = (div_sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : div_sel;
  assign limit = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
  assign tick  = !halt && ({1'b0, pre_q} >= limit);
  assign expire = tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!halt) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  // R10
  clr_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && pre_q == '0));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/wdt_evtgen.sv
module wdt_evtgen #(
  parameter int unsigned PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic mode_rst,
  output logic irq_n,
  output logic rst_req,
  output logic pulse_active
);
  localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [PW-1:0] left_q;
  logic          irq_q;
  logic          rreq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b1;
      rreq_q <= 1'b0;
      left_q <= '0;
    end else begin
      rreq_q <= evt && mode_rst;
      if (evt && !mode_rst) begin
        irq_q  <= 1'b0;
        left_q <= PW'(PULSE_LEN - 1);
      end else if (!irq_q) begin
        if (left_q == '0) irq_q  <= 1'b1;
        else              left_q <= left_q - PW'(1);
      end
    end
  end

  assign irq_n        = irq_q;
  assign rst_req      = rreq_q;
  assign pulse_active = !irq_q;

  // R6
  rst_req_on_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && mode_rst) |=> rst_req);

  // R6
  rst_req_only_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt && mode_rst) |=> !rst_req);

  // R7
  irq_on_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !mode_rst) |=> !irq_n);

  // R8
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && !irq_n));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_SHIFT = 6,
  parameter int unsigned PULSE_LEN = 512,
  parameter logic [7:0]  KEY_ARM   = 8'h55,
  parameter logic [7:0]  KEY_FIRE  = 8'hAA,
  parameter logic [2:0]  GUARD_OK  = 3'b101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       irq_n,
  output logic       rst_req
);
  logic [SEL_W-1:0] div_sel;
  logic             halt;
  logic             mode_rst;
  logic             guard_bad;
  logic             svc;
  logic             expire;
  logic             evt;
  logic             pulse_active;

  assign evt = expire || guard_bad;

  wdt_ctrl_regs #(.GUARD_OK(GUARD_OK)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pulse_active(pulse_active), .expire(expire),
    .div_sel(div_sel), .halt(halt), .mode_rst(mode_rst), .guard_bad(guard_bad)
  );

  wdt_keyseq #(.KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_keys (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .svc(svc)
  );

  wdt_timebase #(.CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)) u_time (
    .clk(clk), .rst(rst), .halt(halt), .div_sel(div_sel),
    .clr(svc || evt), .expire(expire)
  );

  wdt_evtgen #(.PULSE_LEN(PULSE_LEN)) u_evt (
    .clk(clk), .rst(rst), .evt(evt), .mode_rst(mode_rst),
    .irq_n(irq_n), .rst_req(rst_req), .pulse_active(pulse_active)
  );

  // R5
  bad_guard_event_chk: assert property (@(posedge clk) disable iff (rst)
    guard_bad |=> (rst_req || !irq_n));
endmodule

// File: tb/wdt_core_bench.sv
`timescale 1ns/1ps
module wdt_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       irq_n;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nrst = 0;
  bit done = 0;

  wdt_core u_wdt_core (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_n(irq_n), .rst_req(rst_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) nrst <= nrst + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ctrl(input bit mode, input bit hlt, input int sel);
    wr(2'd0, {3'b101, mode, hlt, 3'(sel)});
  endtask

  task automatic service();
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
  endtask

  task automatic wait_evt(output int at);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!(rst_req || !irq_n) && n < 40000);
    at = (n >= 40000) ? -1 : cyc;
  endtask

  task automatic wait_irq_high(output int at);
    int n = 0;
    while (!irq_n && n < 40000) begin
      @(negedge clk); n++;
    end
    at = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, s1, at, h, r, n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle outputs after reset
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    // R1 default reset mode, divide by one
    service(); s0 = cyc; wait_evt(at);
    check(at - s0 == 255 && rst_req, "R1 default expiry", at - s0, 255);

    // R2 R6 sweep of every divide select
    for (int s = 0; s < 8; s++) begin
      int d;
      d = 1 << ((s > 6) ? 6 : s);
      ctrl(1'b1, 1'b0, s);
      service(); s0 = cyc; wait_evt(at);
      check(at - s0 == 255 * d && rst_req, "R2 expiry period", at - s0, 255 * d);
      @(negedge clk);
      check(rst_req == 1'b0, "R6 single cycle", rst_req, 0);
    end

    ctrl(1'b1, 1'b0, 0);
    // R3 lone 0xAA does not service
    service(); s0 = cyc;
    repeat (100) @(negedge clk);
    wr(2'd1, 8'hAA);
    wait_evt(at);
    check(at - s0 == 255, "R3 unarmed AA ignored", at - s0, 255);
    // R3 stray value between keys keeps the arm
    service();
    repeat (100) @(negedge clk);
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA); s1 = cyc;
    wait_evt(at);
    check(at - s1 == 255, "R3 stray value keeps arm", at - s1, 255);

    // R5 R4 bad guard forces event and leaves fields alone
    service();
    repeat (50) @(negedge clk);
    wr(2'd0, 8'h1F); s0 = cyc;
    check(rst_req == 1'b1, "R5 immediate event", rst_req, 1);
    // R10 restart from zero, fields unchanged by bad write
    wait_evt(at);
    check(at - s0 == 255, "R10 restart after event", at - s0, 255);

    // R7 expiry in interrupt mode
    ctrl(1'b0, 1'b0, 0);
    service(); s0 = cyc; wait_evt(at);
    check(at - s0 == 255 && !irq_n && !rst_req, "R7 irq expiry", at - s0, 255);
    ctrl(1'b0, 1'b0, 6);
    wait_irq_high(at);
    check(at - s0 == 255 + 512, "R7 pulse width", at - s0, 255 + 512);
    // R7 retrigger during pulse
    wr(2'd0, 8'h00); s0 = cyc;
    check(irq_n == 1'b0, "R7 bad write irq", irq_n, 0);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h00); s1 = cyc;
    wait_irq_high(at);
    check(at == s1 + 512, "R7 retrigger", at - s0, s1 - s0 + 512);

    // R8 mode write ignored during pulse
    wr(2'd0, 8'h00);
    repeat (100) @(negedge clk);
    ctrl(1'b1, 1'b0, 6);
    wait_irq_high(at);
    wr(2'd0, 8'h00);
    check(irq_n == 1'b0 && rst_req == 1'b0, "R8 mode held", rst_req, 0);
    wait_irq_high(at);
    ctrl(1'b1, 1'b0, 0);
    wr(2'd0, 8'h00);
    check(rst_req == 1'b1 && irq_n == 1'b1, "R8 mode taken after pulse", rst_req, 1);

    // R9 halt freezes the count
    service(); s0 = cyc;
    repeat (20) @(negedge clk);
    ctrl(1'b1, 1'b1, 0); h = cyc;
    n0 = nrst;
    repeat (600) @(negedge clk);
    check(nrst == n0, "R9 no event while halted", nrst - n0, 0);
    ctrl(1'b1, 1'b0, 0); r = cyc;
    wait_evt(at);
    check(at == r + 255 - (h - s0), "R9 resume from held count", at - r, 255 - (h - s0));
    // R9 bad guard while halted
    ctrl(1'b1, 1'b1, 0);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h00);
    check(rst_req == 1'b1, "R9 bad guard while halted", rst_req, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule